// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block watches two clocks, bank A and bank C, that are both divided down from one source clock with known divide ratios, and issues an active-low warning pulse ahead of the next rising edge that the two banks share. The pulse drops one period of the faster bank clock before the shared edge and rises on the source edge where that shared edge happens. A downstream consumer can therefore tell, one fast-clock period ahead, that the two domains are about to line up. This matters most when the ratio between the banks is not an integer, such as 3:2 or 4:3.

The block runs on the source clock and follows the dividers' common phase origin. It keeps one phase counter that runs modulo the least common multiple of the two divide values. The counter is at zero on the source edges where both bank clocks rise together. Bank A is divided by 4, 6, 8 or 12 and bank C by 2, 4, 6 or 8, each chosen with a 2-bit select. A new selection takes effect only at the next common origin, so the pattern already in progress is never cut short.

Top module: `coincident_sync_gen`

## Requirements
- R1: While `rst_n` is low, each rising edge of `clk` sets `sync_n` to 1 and puts the phase origin at the next edge. Phase k is the number of rising edges seen with `rst_n` high since reset.
- R2: `sel_a` selects the bank A divide: 2'b00 gives 4, 2'b01 gives 6, 2'b10 gives 8 and 2'b11 gives 12. `sel_c` selects the bank C divide: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 6 and 2'b11 gives 8.
- R3: The coincident rising edges of the two banks fall at phases that are multiples of L, the least common multiple of the two divides. Consecutive rising edges of `sync_n` are exactly L source cycles apart.
- R4: When the two divides differ, `sync_n` is 0 for exactly W source cycles before each coincident edge, where W is the smaller divide. At all other phases it is 1.
- R5: At every coincident edge (phase a multiple of L) `sync_n` is 1, and a rising edge of `sync_n` occurs only there.
- R6: When the two divides are equal (1:1), `sync_n` is 0 for half the common divide before each rising edge, and 1 otherwise.
- R7: A change of `sel_a` or `sel_c` after reset takes effect only at the next coincident edge. Until that edge the pattern of the old configuration continues, and from that edge the new configuration starts at phase 0.
- R8: Non-integer ratios follow R3 and R4 unchanged. For example, A/6 with C/4 gives L=12 and W=4, and A/6 with C/8 gives L=24 and W=6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared with the bank dividers |
| rst_n | input | 1 | Synchronous active-low reset; sets the common phase origin |
| sel_a | input | 2 | Bank A divide select |
| sel_c | input | 2 | Bank C divide select |
| sync_n | output | 1 | Active-low warning of the next coincident rising edge |

## Verification
The bench goes through every divide pairing. It measures the spacing between rises of the warning pulse and checks that pulse against the cycle-by-cycle reference in the 1:1, integer and non-integer ratios. A design that used the product of the divides instead of their least common multiple would show the rises too far apart in the 3:2 and 4:3 cases. A design that used the full fast period in the 1:1 case would hold the output low all the time. A selection change in the middle of a long 4:3 pattern is checked at a phase where the new pattern would already be low: a design that reconfigures at once instead of at the next origin drops the pulse early there.

// File: rtl/csync_pkg.sv
package csync_pkg;
    localparam int SEL_W = 2;
    localparam int DIV_W = 5;
    localparam int CNT_W = 5;

    function automatic logic [DIV_W-1:0] bank_a_divide(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   return DIV_W'(4);
            2'b01:   return DIV_W'(6);
            2'b10:   return DIV_W'(8);
            default: return DIV_W'(12);
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] bank_c_divide(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   return DIV_W'(2);
            2'b01:   return DIV_W'(4);
            2'b10:   return DIV_W'(6);
            default: return DIV_W'(8);
        endcase
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] phase;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] window;
        logic             sync_n;
    } csync_state_t;
endpackage

// File: rtl/csync_ratio_decode.sv
module csync_ratio_decode
    import csync_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DIV_W
) (
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_c,
    output logic [DW-1:0] div_a,
    output logic [DW-1:0] div_c
);
    always_comb begin
        div_a = DW'(bank_a_divide(SEL_W'(sel_a)));
        div_c = DW'(bank_c_divide(SEL_W'(sel_c)));
    end
endmodule

// File: rtl/csync_period_calc.sv
module csync_period_calc #(
    parameter int DW       = 5,
    parameter int CW       = 5,
    parameter int MAX_MULT = 8
) (
    input  logic [DW-1:0] div_a,
    input  logic [DW-1:0] div_c,
    output logic [CW-1:0] period,
    output logic [CW-1:0] window
);
    int  cand;
    int  lcm_v;
    logic found;
    logic [DW-1:0] fast;

    // least common multiple: first multiple of div_a that div_c divides
    always_comb begin
        lcm_v = int'(div_a) * int'(div_c);
        found = 1'b0;
        cand  = 0;
        for (int m = 1; m <= MAX_MULT; m++) begin
            cand = int'(div_a) * m;
            if (!found && (div_c != '0) && ((cand % int'(div_c)) == 0)) begin
                lcm_v = cand;
                found = 1'b1;
            end
        end
        period = CW'(lcm_v);
    end

    // warning width: one fast period, or half of it when the banks match
    always_comb begin
        fast = (div_a < div_c) ? div_a : div_c;
        if (div_a == div_c) window = CW'(fast >> 1);
        else                window = CW'(fast);
    end
endmodule

// File: rtl/csync_core.sv
module csync_core
    import csync_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_in,
    input  logic [CW-1:0] window_in,
    output logic          sync_n,
    output logic [CW-1:0] phase_o,
    output logic [CW-1:0] period_o,
    output logic [CW-1:0] window_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] phase;
        logic [CW-1:0] period;
        logic [CW-1:0] window;
        logic          sync_n;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.phase  = '0;
            st_d.period = period_in;
            st_d.window = window_in;
            st_d.sync_n = 1'b1;
        end else begin
            if (st_q.phase == st_q.period - ONE) begin
                st_d.phase  = '0;
                st_d.period = period_in;
                st_d.window = window_in;
            end else begin
                st_d.phase  = st_q.phase + ONE;
            end
            st_d.sync_n = !(st_d.phase >= st_d.period - st_d.window);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_n   = st_q.sync_n;
    assign phase_o  = st_q.phase;
    assign period_o = st_q.period;
    assign window_o = st_q.window;
endmodule

// File: rtl/coincident_sync_gen.sv
module coincident_sync_gen
    import csync_pkg::*;
#(
    parameter int SW       = SEL_W,
    parameter int DW       = DIV_W,
    parameter int CW       = CNT_W,
    parameter int MAX_MULT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_c,
    output logic          sync_n
);
    logic [DW-1:0] div_a_w, div_c_w;
    logic [CW-1:0] period_w, window_w;
    logic [CW-1:0] phase_q_w, period_q_w, window_q_w;

    csync_ratio_decode #(.SW(SW), .DW(DW)) u_decode (
        .sel_a (sel_a),
        .sel_c (sel_c),
        .div_a (div_a_w),
        .div_c (div_c_w)
    );

    csync_period_calc #(.DW(DW), .CW(CW), .MAX_MULT(MAX_MULT)) u_calc (
        .div_a  (div_a_w),
        .div_c  (div_c_w),
        .period (period_w),
        .window (window_w)
    );

    csync_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period_w),
        .window_in (window_w),
        .sync_n    (sync_n),
        .phase_o   (phase_q_w),
        .period_o  (period_q_w),
        .window_o  (window_q_w)
    );
endmodule

// File: rtl/coincident_sync_gen_chk.sv
module coincident_sync_gen_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_n,
    input logic [CW-1:0] phase,
    input logic [CW-1:0] period,
    input logic [CW-1:0] window
);
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase < period);

    p_low_before_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == period - CW'(1)) |-> !sync_n);

    p_fall_at_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> (phase == period - window));

    p_high_at_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> sync_n);

    p_rise_only_at_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (phase == '0));

    p_config_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> ($stable(period) && $stable(window)));
endmodule

bind coincident_sync_gen coincident_sync_gen_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .phase  (phase_q_w),
    .period (period_q_w),
    .window (window_q_w)
);

// File: tb/coincident_sync_gen_tb.sv
module coincident_sync_gen_tb;
    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_a = 2'b00;
    logic [1:0] sel_c = 2'b00;
    logic       sync_n;

    int errors = 0;
    int checks = 0;
    int kmod   = 0;
    int lm     = 4;
    int wm     = 2;

    always #2 clk = ~clk;

    coincident_sync_gen u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (sel_a),
        .sel_c  (sel_c),
        .sync_n (sync_n)
    );

    function automatic int ref_a(input logic [1:0] s);
        int t[4] = '{4, 6, 8, 12};
        return t[s];
    endfunction

    function automatic int ref_c(input logic [1:0] s);
        return 2 * (int'(s) + 1);
    endfunction

    function automatic int ref_lcm(input int a, input int c);
        for (int v = c; v <= a * c; v += c)
            if (v % a == 0) return v;
        return a * c;
    endfunction

    function automatic int ref_win(input int a, input int c);
        if (a == c) return a / 2;
        return (a < c) ? a : c;
    endfunction

    // reference phase model, reloading only at the shared origin
    always @(posedge clk) begin
        if (!rst_n) begin
            kmod = 0;
            lm   = ref_lcm(ref_a(sel_a), ref_c(sel_c));
            wm   = ref_win(ref_a(sel_a), ref_c(sel_c));
        end else begin
            kmod = kmod + 1;
            if (kmod == lm) begin
                kmod = 0;
                lm   = ref_lcm(ref_a(sel_a), ref_c(sel_c));
                wm   = ref_win(ref_a(sel_a), ref_c(sel_c));
            end
        end
    end

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sync_n=%b expected %b (phase %0d of %0d)", tag, act, exp, kmod, lm);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            begin
                int remain;
                logic exp;
                remain = lm - kmod;
                exp    = (kmod != 0 && remain <= wm) ? 1'b0 : 1'b1;
                chk_bit(tag, sync_n, exp);
                if (kmod == 0) chk_bit("R5", sync_n, 1'b1);
            end
        end
    endtask

    task automatic apply_reset(input logic [1:0] sa, input logic [1:0] sc);
        @(negedge clk);
        rst_n = 1'b0;
        sel_a = sa;
        sel_c = sc;
        repeat (3) @(negedge clk);
        chk_bit("R1", sync_n, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        apply_reset(2'b11, 2'b11);
        run(2, "R1");
    endtask

    task automatic t_equal_ratio;
        apply_reset(2'b00, 2'b01);  // A/4, C/4
        run(24, "R6");
        apply_reset(2'b10, 2'b11);  // A/8, C/8
        run(32, "R6");
    endtask

    task automatic t_integer_ratio;
        apply_reset(2'b00, 2'b00);  // A/4, C/2
        run(24, "R4");
        apply_reset(2'b01, 2'b00);  // A/6, C/2
        run(24, "R3");
        apply_reset(2'b11, 2'b00);  // A/12, C/2
        run(36, "R3");
    endtask

    task automatic t_fractional_ratio;
        apply_reset(2'b01, 2'b01);  // A/6, C/4 -> L=12 W=4
        run(36, "R8");
        apply_reset(2'b01, 2'b11);  // A/6, C/8 -> L=24 W=6
        run(72, "R8");
    endtask

    task automatic t_decode_periods;
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 4; c++) begin
                int first_rise;
                int second_rise;
                logic prev;
                first_rise  = -1;
                second_rise = -1;
                apply_reset(2'(a), 2'(c));
                prev = 1'b1;
                for (int cyc = 1; cyc <= 60; cyc++) begin
                    @(negedge clk);
                    if (sync_n && !prev) begin
                        if (first_rise < 0) first_rise = cyc;
                        else if (second_rise < 0) second_rise = cyc;
                    end
                    prev = sync_n;
                end
                chk_int("R2", first_rise, ref_lcm(ref_a(2'(a)), ref_c(2'(c))));
                chk_int("R3", second_rise - first_rise, ref_lcm(ref_a(2'(a)), ref_c(2'(c))));
            end
        end
    endtask

    task automatic t_mid_change;
        apply_reset(2'b01, 2'b11);  // A/6, C/8 -> L=24
        run(5, "R7");
        sel_a = 2'b00;              // A/4, C/2 -> L=4
        sel_c = 2'b00;
        run(5, "R7");               // phase 10: old pattern high, new one would be low
        chk_bit("R7", sync_n, 1'b1);
        run(40, "R7");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset_state();
        t_equal_ratio();
        t_integer_ratio();
        t_fractional_ratio();
        t_decode_periods();
        t_mid_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule